// File: doc/BRIEF.md
# Three-Segment Multiply-Add Pipeline

This block computes `a * b + c` on unsigned integers for a stream of operand triples and accepts a new triple on every clock. The work is split over three register segments. The first captures the two multiplicands. The second forms their product and, on the same edge, captures the addend. The third adds the two and holds the sum. The caller presents `a`, `b` and `c` together, qualified by `in_valid`. The first segment holds `c` back by one clock so that it meets its own product in segment two.

A valid flag travels with each segment. The result port therefore carries a qualifier that is high exactly when the sum register holds a real result. The pipeline never stalls. The sum is one bit wider than a full product, so no combination of operands can overflow it. A synchronous reset clears the valid flags only; the data registers keep whatever they hold.

Top module: `muladd_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is 0 after that edge, and it stays 0 until a triple that was accepted after reset has passed all three segments.
- R2: A triple sampled with `in_valid` high at rising edge k shows up with `out_valid` high right after edge k+2, which is the third edge counting the sampling edge. Nothing appears after the two edges before it.
- R3: The result is `a*b + c`, computed as an unsigned value of 2*W+1 bits with no wrap. For W=4 and all operands at 15 it equals 240; with all operands at 0 it equals 0.
- R4: Triples fed on n consecutive clocks all complete by edge n+2 (k+n-1 cycles for k=3), with one result per clock and no gaps between results.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low three edges later, whatever values sit on the operand inputs during it.
- R6: All three operands of a triple are presented in the same cycle. The `c` that is added to a product is the one that arrived with that product's `a` and `b`, even when `c` changes on every clock.
- R7: Triples that are still inside the pipeline when reset is sampled are dropped and never raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every segment advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | The operand triple on this cycle is real |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_c | input | W | Addend, presented together with `in_a` and `in_b` |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 2*W+1 | `a*b + c` of the triple that entered three edges earlier |

## Verification
The checker takes for granted that reset is asserted before the first useful edge, and that the operand inputs hold known values in every cycle the latency and result properties compare. The data registers are never reset, so the checks only look at cycles that lie three clean edges after the last reset. The stimulus starts with reset held for two cycles and drives every input on the falling edge. During idle cycles it still drives defined junk operands, so the invalid cycles carry known values that a correct design must ignore.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

    // Default operand width for the pipeline.
    localparam int unsigned DEF_OPW = 8;

    // Number of register segments between input and result.
    localparam int unsigned SEG_COUNT = 3;

    // Width of a full unsigned product of two w-bit operands.
    function automatic int unsigned prod_width(input int unsigned w);
        return 2 * w;
    endfunction

    // Width that holds a full product plus one w-bit addend without wrap.
    function automatic int unsigned sum_width(input int unsigned w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/mac_seg_load.sv
// Segment one: captures the multiplicands and holds the addend back one clock.
module mac_seg_load
    import muladd_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic         seg_valid,
    output logic [W-1:0] seg_a,
    output logic [W-1:0] seg_b,
    output logic [W-1:0] seg_c
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
    } load_t;

    load_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_valid <= 1'b0;
        end else begin
            seg_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        held <= '{a: in_a, b: in_b, c: in_c};
    end

    assign seg_a = held.a;
    assign seg_b = held.b;
    assign seg_c = held.c;

endmodule

// File: rtl/mac_seg_mul.sv
// Segment two: product of the held multiplicands, addend registered alongside.
module mac_seg_mul
    import muladd_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     up_valid,
    input  logic [W-1:0]             up_a,
    input  logic [W-1:0]             up_b,
    input  logic [W-1:0]             up_c,
    output logic                     seg_valid,
    output logic [prod_width(W)-1:0] seg_prod,
    output logic [W-1:0]             seg_c
);

    localparam int unsigned PW = prod_width(W);

    typedef struct packed {
        logic [PW-1:0] prod;
        logic [W-1:0]  c;
    } mul_t;

    mul_t          held;
    logic [PW-1:0] prod_next;

    always_comb begin
        prod_next = PW'(up_a) * PW'(up_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_valid <= 1'b0;
        end else begin
            seg_valid <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        held <= '{prod: prod_next, c: up_c};
    end

    assign seg_prod = held.prod;
    assign seg_c    = held.c;

endmodule

// File: rtl/mac_seg_add.sv
// Segment three: sum of product and addend into the result register.
module mac_seg_add
    import muladd_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     up_valid,
    input  logic [prod_width(W)-1:0] up_prod,
    input  logic [W-1:0]             up_c,
    output logic                     seg_valid,
    output logic [sum_width(W)-1:0]  seg_sum
);

    localparam int unsigned SW = sum_width(W);

    logic [SW-1:0] sum_next;

    always_comb begin
        sum_next = SW'(up_prod) + SW'(up_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_valid <= 1'b0;
        end else begin
            seg_valid <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        seg_sum <= sum_next;
    end

endmodule

// File: rtl/muladd_pipe.sv
// Top: three segments in a chain, one triple accepted per clock.
module muladd_pipe
    import muladd_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [W-1:0]            in_a,
    input  logic [W-1:0]            in_b,
    input  logic [W-1:0]            in_c,
    output logic                    out_valid,
    output logic [sum_width(W)-1:0] out_sum
);

    localparam int unsigned PW = prod_width(W);

    logic          ld_valid;
    logic [W-1:0]  ld_a;
    logic [W-1:0]  ld_b;
    logic [W-1:0]  ld_c;

    logic          mul_valid;
    logic [PW-1:0] mul_prod;
    logic [W-1:0]  mul_c;

    mac_seg_load #(.W(W)) u_load (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .seg_valid (ld_valid),
        .seg_a     (ld_a),
        .seg_b     (ld_b),
        .seg_c     (ld_c)
    );

    mac_seg_mul #(.W(W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .up_valid  (ld_valid),
        .up_a      (ld_a),
        .up_b      (ld_b),
        .up_c      (ld_c),
        .seg_valid (mul_valid),
        .seg_prod  (mul_prod),
        .seg_c     (mul_c)
    );

    mac_seg_add #(.W(W)) u_add (
        .clk       (clk),
        .rst       (rst),
        .up_valid  (mul_valid),
        .up_prod   (mul_prod),
        .up_c      (mul_c),
        .seg_valid (out_valid),
        .seg_sum   (out_sum)
    );

endmodule

// File: rtl/muladd_pipe_chk.sv
// Property checker attached to the pipeline top.
module muladd_pipe_chk
    import muladd_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [W-1:0]            in_a,
    input logic [W-1:0]            in_b,
    input logic [W-1:0]            in_c,
    input logic                    mid_valid,
    input logic                    out_valid,
    input logic [sum_width(W)-1:0] out_sum
);

    localparam int unsigned SW = sum_width(W);

    // Clean edges since reset, saturating at the pipeline depth.
    logic [1:0] clean_edges;

    always_ff @(posedge clk) begin
        if (rst) begin
            clean_edges <= 2'd0;
        end else if (clean_edges != 2'd3) begin
            clean_edges <= clean_edges + 2'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (clean_edges == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    result_chk: assert property (@(posedge clk) disable iff (rst)
        (clean_edges == 2'd3 && out_valid) |->
        (out_sum == SW'($past(in_a, 3)) * SW'($past(in_b, 3)) + SW'($past(in_c, 3))));

    // R4
    mid_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (clean_edges >= 2'd2) |-> (mid_valid == $past(in_valid, 2)));

endmodule

bind muladd_pipe muladd_pipe_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .mid_valid (mul_valid),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/muladd_pipe_test.sv
`timescale 1ns/1ps
module muladd_pipe_test;

    localparam int W  = 4;
    localparam int SW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  in_a;
    logic [W-1:0]  in_b;
    logic [W-1:0]  in_c;
    logic          out_valid;
    logic [SW-1:0] out_sum;

    int   n_run  = 0;
    int   n_fail = 0;
    int   seen   = 0;
    logic done   = 1'b0;

    // Expected-result delay line, index 2 is the one due at the output.
    logic          mv [3];
    logic [SW-1:0] ms [3];

    always #10 clk = ~clk;

    muladd_pipe #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input logic r, input string tag);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_c     = c;
        rst      = r;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 3; i++) mv[i] = 1'b0;
        end else begin
            mv[2] = mv[1]; ms[2] = ms[1];
            mv[1] = mv[0]; ms[1] = ms[0];
            mv[0] = v;
            ms[0] = SW'(a) * SW'(b) + SW'(c);
        end
        @(negedge clk);
        n_run++;
        if (out_valid !== mv[2]) begin
            n_fail++;
            $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, mv[2]);
        end
        if (mv[2]) begin
            n_run++;
            if (out_sum !== ms[2]) begin
                n_fail++;
                $display("FAIL %s out_sum actual %0d expected %0d", tag, out_sum, ms[2]);
            end
        end
        if (out_valid === 1'b1) seen++;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            mv[i] = 1'b0;
            ms[i] = '0;
        end
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_c = '0;
        @(negedge clk);

        // R1: reset clears the output qualifier
        step(1'b0, 4'd9, 4'd9, 4'd9, 1'b1, "R1");
        step(1'b1, 4'd9, 4'd9, 4'd9, 1'b1, "R1");
        step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R1");

        // R2: lone triple, result three edges later
        step(1'b1, 4'd3, 4'd5, 4'd7, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 4'd1, 4'd2, 4'd3, 1'b0, "R2");

        // R3: width corners (15*15+15 = 240, zero)
        step(1'b1, 4'd15, 4'd15, 4'd15, 1'b0, "R3");
        step(1'b1, 4'd0,  4'd0,  4'd0,  1'b0, "R3");
        step(1'b1, 4'd15, 4'd0,  4'd15, 1'b0, "R3");
        step(1'b1, 4'd0,  4'd15, 4'd1,  1'b0, "R3");
        for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R3");

        // R6: exhaustive a,b sweep back to back, addend changing every clock
        seen = 0;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, W'(a), W'(b), W'(a * 7 + b * 3), 1'b0, "R6");
            end
        end
        step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R4");
        step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R4");
        // R4: 256 triples complete by edge n+2
        n_run++;
        if (seen != 256) begin
            n_fail++;
            $display("FAIL R4 results seen actual %0d expected %0d", seen, 256);
        end
        step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R4");

        // R5: gapped stream with junk on idle cycles
        for (int i = 0; i < 20; i++) begin
            step((i % 2) == 0, W'(i), W'(~i), W'(i * 5), 1'b0, "R5");
        end
        for (int i = 0; i < 3; i++) step(1'b0, 4'd15, 4'd15, 4'd15, 1'b0, "R5");

        // R7: reset drops triples still in flight
        step(1'b1, 4'd6, 4'd7, 4'd8, 1'b0, "R7");
        step(1'b1, 4'd9, 4'd2, 4'd4, 1'b0, "R7");
        step(1'b0, 4'd0, 4'd0, 4'd0, 1'b1, "R7");
        for (int i = 0; i < 4; i++) step(1'b0, 4'd5, 4'd5, 4'd5, 1'b0, "R7");
        step(1'b1, 4'd2, 4'd3, 4'd4, 1'b0, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule